// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a write-through cache and a slow memory port. Every store the processor commits to the cache is also handed to this queue in the same cycle. The processor can then move on without waiting for memory. A drain engine on the memory side takes the oldest queued store, presents it to memory, and removes it once memory acknowledges the write. Stores therefore reach memory one at a time and in the order they were accepted.

The queue holds four entries by default, each with a 32-bit address and 32-bit data. It only stalls the store port when every slot is occupied. Stores can flow without stalls as long as, on average, fewer than one store arrives per memory write cycle.

A load that hits an address still waiting in the queue gets that address's most recently accepted data from the queue. A clean flag tells the cache controller that no write is outstanding, so memory holds every stored value.

The drain engine has two named states. In `DR_IDLE` the queue is empty and no request is made. In `DR_WRITE` the head entry is presented to memory. The transitions are:

- `DR_IDLE` goes to `DR_WRITE` when a store is accepted.
- `DR_WRITE` stays in `DR_WRITE` while entries remain after an acknowledge, or while no acknowledge arrives.
- `DR_WRITE` goes to `DR_IDLE` when the last entry is acknowledged and no store arrives in that cycle.

Top module: `wt_store_queue`

## Requirements
- R1: While reset is held low and just after reset, `st_ready` is 1, `mem_req` is 0, `mem_clean` is 1 and `ld_hit` is 0.
- R2: With fewer than DEPTH entries held, `st_ready` is 1, and a store offered with `st_valid`=1 is accepted at the next rising edge.
- R3: With DEPTH entries held and `mem_ack`=0, `st_ready` is 0, an offered store is not accepted, and the queue contents do not change.
- R4: With DEPTH entries held and `mem_ack`=1, `st_ready` is 1. An offered store is accepted in the same edge that the head entry retires, so the entry count stays at DEPTH.
- R5: `mem_req` is 1 exactly when at least one entry is held. `mem_addr` and `mem_data` then show the oldest entry. Each edge with `mem_req`=1 and `mem_ack`=1 retires exactly that entry, so memory sees stores in acceptance order.
- R6: `mem_clean` is 1 exactly when no entry is held.
- R7: With `ld_valid`=1 and `ld_addr` equal to the address of one or more held entries, `ld_hit` is 1 and `ld_data` equals the data of the most recently accepted of those entries. This is evaluated in the same cycle, without a register.
- R8: With `ld_valid`=0, or with no held entry whose address matches, `ld_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor offers a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store can be accepted this cycle |
| ld_valid | input | 1 | Load address valid for lookup |
| ld_addr | input | AW | Load address |
| ld_hit | output | 1 | A held entry matches the load address |
| ld_data | output | DW | Data of the youngest matching entry |
| mem_req | output | 1 | Memory write requested for head entry |
| mem_addr | output | AW | Head entry address |
| mem_data | output | DW | Head entry data |
| mem_ack | input | 1 | Memory accepts the requested write |
| mem_clean | output | 1 | Queue empty, memory up to date |

## Verification
The hardest situation to reach is a full queue that receives a store and a memory acknowledge in the same edge, particularly while a load is looking up an address held several times. The stimulus creates it deliberately. It first holds `mem_ack` low with stores streaming in, which fills all slots and exposes the stall. It then raises the acknowledge while stores keep arriving. The store addresses come from a set of only six values, so duplicate addresses pile up and the youngest-match selection is exercised. A long random phase with a low acknowledge rate then keeps the queue near full for many cycles.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    typedef enum logic [0:0] {
        DR_IDLE  = 1'b0,
        DR_WRITE = 1'b1
    } drain_state_e;

    function automatic int wrap_idx(input int base, input int step, input int depth);
        int s;
        s = base + step;
        if (s >= depth) s = s - depth;
        return s;
    endfunction
endpackage

// File: rtl/wsq_ring.sv
module wsq_ring #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic                pop,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    output logic [AW-1:0]       head_addr,
    output logic [DW-1:0]       head_data,
    output logic [CW-1:0]       count,
    output logic [PW-1:0]       rd_ptr,
    output logic [AW-1:0]       slot_addr [DEPTH],
    output logic [DW-1:0]       slot_data [DEPTH]
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [PW-1:0] wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == PW'(g))) begin
                slot_addr[g] <= wr_addr;
                slot_data[g] <= wr_data;
            end
        end
    end

    always_comb begin
        head_addr = slot_addr[rd_ptr];
        head_data = slot_data[rd_ptr];
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((count != FULL_CNT) || pop))
        else $error("push into full ring without pop");

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0))
        else $error("pop from empty ring");

    p_count_balanced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count))
        else $error("count moved on simultaneous push and pop");
endmodule

// File: rtl/wsq_match.sv
module wsq_match #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW-1:0] rd_ptr,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] slot_addr [DEPTH],
    input  logic [DW-1:0] slot_data [DEPTH],
    output logic          hit,
    output logic [DW-1:0] data
);
    import wsq_pkg::*;

    // Walk from oldest to youngest so that a later match overrides.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int idx;
            idx = wrap_idx(int'(rd_ptr), k, DEPTH);
            if (ld_valid && (k < int'(count)) && (slot_addr[idx] == ld_addr)) begin
                hit  = 1'b1;
                data = slot_data[idx];
            end
        end
    end

    p_hit_needs_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (count != '0))
        else $error("load hit with empty ring");

    p_no_hit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !hit)
        else $error("load hit without valid load");
endmodule

// File: rtl/wsq_drain.sv
module wsq_drain #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] count,
    output logic          mem_req,
    output logic          clean
);
    import wsq_pkg::*;

    drain_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DR_IDLE:  if (push) state_nx = DR_WRITE;
            DR_WRITE: if (pop && !push && (count == CW'(1))) state_nx = DR_IDLE;
            default:  state_nx = DR_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        clean   = 1'b1;
        unique case (state)
            DR_IDLE:  begin mem_req = 1'b0; clean = 1'b1; end
            DR_WRITE: begin mem_req = 1'b1; clean = 1'b0; end
            default:  begin mem_req = 1'b0; clean = 1'b1; end
        endcase
    end

    p_req_tracks_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req == (count != '0))
        else $error("request disagrees with ring occupancy");

    p_clean_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clean |-> !mem_req)
        else $error("clean while request pending");
endmodule

// File: rtl/wt_store_queue.sv
module wt_store_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_ready,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_ack,
    output logic          mem_clean
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic          push, pop;
    logic [CW-1:0] count;
    logic [PW-1:0] rd_ptr;
    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];

    assign pop      = mem_req && mem_ack;
    assign st_ready = (count != FULL_CNT) || pop;
    assign push     = st_valid && st_ready;

    wsq_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wr_addr(st_addr), .wr_data(st_data),
        .head_addr(mem_addr), .head_data(mem_data),
        .count(count), .rd_ptr(rd_ptr),
        .slot_addr(slot_addr), .slot_data(slot_data)
    );

    wsq_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .rd_ptr(rd_ptr), .count(count),
        .slot_addr(slot_addr), .slot_data(slot_data),
        .hit(ld_hit), .data(ld_data)
    );

    wsq_drain #(.DEPTH(DEPTH)) u_drain (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .count(count),
        .mem_req(mem_req), .clean(mem_clean)
    );

    p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == FULL_CNT) && !mem_ack) |-> !st_ready)
        else $error("store port ready while full");

    p_head_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)))
        else $error("head changed without acknowledge");

    p_ready_not_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count != FULL_CNT) |-> st_ready)
        else $error("store port stalled below full");
endmodule

// File: tb/wt_store_queue_tb.sv
module wt_store_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, ld_valid = 1'b0, mem_ack = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
    logic        st_ready, ld_hit, mem_req, mem_clean;
    logic [31:0] ld_data, mem_addr, mem_data;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [31:0] qa[$];
    logic [31:0] qd[$];

    always #10 clk = ~clk;

    wt_store_queue u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ack(mem_ack), .mem_clean(mem_clean)
    );

    task automatic chk(input string req, input string sig, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, sig, act, exp, $time);
        end
    endtask

    task automatic compare_all(input bit in_reset);
        bit          e_hit;
        logic [31:0] e_data;
        int          n;
        string       rtag;
        n = qa.size();
        e_hit = 1'b0;
        e_data = '0;
        if (ld_valid)
            for (int i = 0; i < n; i++)
                if (qa[i] == ld_addr) begin e_hit = 1'b1; e_data = qd[i]; end
        if (in_reset) begin
            chk("R1", "st_ready", {31'b0, st_ready}, 32'd1);
            chk("R1", "mem_req", {31'b0, mem_req}, 32'd0);
            chk("R1", "mem_clean", {31'b0, mem_clean}, 32'd1);
            chk("R1", "ld_hit", {31'b0, ld_hit}, 32'd0);
            return;
        end
        rtag = (n == 4) ? (mem_ack ? "R4" : "R3") : "R2";
        chk(rtag, "st_ready", {31'b0, st_ready}, {31'b0, (n < 4) || (n > 0 && mem_ack)});
        chk("R5", "mem_req", {31'b0, mem_req}, {31'b0, n > 0});
        if (n > 0) begin
            chk("R5", "mem_addr", mem_addr, qa[0]);
            chk("R5", "mem_data", mem_data, qd[0]);
        end
        chk("R6", "mem_clean", {31'b0, mem_clean}, {31'b0, n == 0});
        chk(e_hit ? "R7" : "R8", "ld_hit", {31'b0, ld_hit}, {31'b0, e_hit});
        if (e_hit) chk("R7", "ld_data", ld_data, e_data);
    endtask

    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] d,
                        input bit lv, input logic [31:0] la, input bit ack);
        bit p_pop, p_push;
        @(negedge clk);
        st_valid = v; st_addr = a; st_data = d;
        ld_valid = lv; ld_addr = la; mem_ack = ack;
        #1;
        compare_all(1'b0);
        @(posedge clk);
        p_pop  = (qa.size() > 0) && ack;
        p_push = v && ((qa.size() < 4) || p_pop);
        if (p_pop) begin void'(qa.pop_front()); void'(qd.pop_front()); end
        if (p_push) begin qa.push_back(a); qd.push_back(d); end
    endtask

    function automatic logic [31:0] pick_addr(input int k);
        return 32'h0000_1000 + 32'(k % 6) * 32'd4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        compare_all(1'b1);               // R1 under reset
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0);          // R1 after release: regular compare on empty model

        // R2: single store, memory slow, then acknowledged
        step(1, pick_addr(0), 32'hA000_0001, 0, 0, 0);
        step(0, 0, 0, 1, pick_addr(0), 0);
        step(0, 0, 0, 1, pick_addr(0), 1);
        step(0, 0, 0, 1, pick_addr(0), 0);

        // R3: fill with duplicates, memory silent
        for (int i = 0; i < 7; i++)
            step(1, pick_addr(i % 2), 32'hB000_0000 + 32'(i), 1, pick_addr(i % 2), 0);
        // R7/R8: probe every address while full
        for (int i = 0; i < 6; i++)
            step(0, 0, 0, 1, pick_addr(i), 0);
        // R4: full with acknowledge and new stores
        for (int i = 0; i < 4; i++)
            step(1, pick_addr(i + 2), 32'hC000_0000 + 32'(i), 1, pick_addr(i), 1);

        // random traffic, low acknowledge rate
        for (int i = 0; i < 3000; i++)
            step(($urandom % 2) == 0, pick_addr(int'($urandom % 6)), $urandom,
                 ($urandom % 4) != 0, pick_addr(int'($urandom % 7)), ($urandom % 3) == 0);

        // R6: drain to empty
        for (int i = 0; i < 8; i++)
            step(0, 0, 0, 1, pick_addr(i), 1);
        step(0, 0, 0, 0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule